// File: doc/BRIEF.md
# Dual-Clock Packet FIFO with Start Threshold

This block carries framed data packets from one clock to another. The two clocks run at the same nominal rate but come from separate oscillators. On the write side, each word arrives with a start-of-packet mark and an end-of-packet mark. Inside a packet, the writer supplies a word on every cycle, and it pauses only between packets. The read side is push-style: once the block begins presenting a packet, it aims to present one word per read cycle until the end mark. This lets a downstream consumer rely on an unbroken stream.

The write and read pointers cross between the clocks as Gray code through a chain of synchronizer flops. All read-side flags come from the read domain's view of occupancy: the synchronized write pointer minus the local read pointer.

- The almost-empty flag is a pure level compare on that occupancy. It therefore behaves the same while the buffer is filling from empty as while it is draining.
- A start gate holds the first word of a packet back until at least `START_LEVEL` words are held. This builds a margin that absorbs the small rate difference between the clocks.
- A packet made of a single word, with both marks on that word, is let through as soon as it is held. It has no following word to wait for.

The read controller is a three-state machine:

- **ST_IDLE** waits between packets. Transition *start*: when the gate opens, it pops the head word and moves to ST_STREAM. If the popped word carries the end mark, it stays in ST_IDLE.
- **ST_STREAM** pops one word per cycle. Transition *finish*: popping the end-marked word returns to ST_IDLE. Transition *starve*: finding the buffer empty moves to ST_HOLD and presents nothing.
- **ST_HOLD** waits for data after a starve. Transition *resume*: the next word pops and streaming continues. Starving can only happen if the writer breaks its gap-free contract.

Top module: `pkt_afifo`

## Requirements
- R1: After both resets, `rd_empty` = 1, `rd_aempty` = 1, `rd_valid` = 0 and `wr_full` = 0.
- R2: Words leave in write order, with data, `sop` and `eop` unchanged. Every presented packet opens with a word carrying `rd_sop` = 1, and no word with `rd_sop` = 1 appears before the previous packet's `rd_eop` word.
- R3: The first word of a packet whose first word lacks the end mark is not presented while fewer than `START_LEVEL` (default 2) words are held. A lone non-final word waits indefinitely.
- R4: A single-word packet (`sop` = 1 and `eop` = 1 on the same word) is presented while it is the only word held.
- R5: `rd_aempty` is 1 whenever the read-side occupancy is at most `AE_LEVEL` (default 1), including while the buffer fills from empty, and 0 when more words are held.
- R6: When the writer keeps its contract (no idle cycles inside a packet, clocks at equal nominal rate), `rd_valid` stays 1 on every read cycle from the `rd_sop` word through the `rd_eop` word.
- R7: If the writer pauses inside a packet, output pauses (`rd_valid` = 0) and resumes with no word lost, repeated or reordered.
- R8: `rd_empty` is 1 exactly when the read side sees zero words held. After a packet drains, `rd_empty` and `rd_aempty` both return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write strobe; the word is stored unless the buffer is full |
| wr_sop | input | 1 | Marks the first word of a packet |
| wr_eop | input | 1 | Marks the last word of a packet |
| wr_data | input | DATA_W | Write data word |
| wr_full | output | 1 | All DEPTH slots occupied, as seen by the write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_valid | output | 1 | A word is presented this read cycle |
| rd_sop | output | 1 | Start mark of the presented word |
| rd_eop | output | 1 | End mark of the presented word |
| rd_data | output | DATA_W | Presented data word |
| rd_empty | output | 1 | Read side sees no words held |
| rd_aempty | output | 1 | Read side sees AE_LEVEL words or fewer held |

## Verification
A wrong read pointer or a mis-decoded Gray pointer shows up within a few read cycles. It appears as a word out of order, a duplicated word, or a misplaced start or end mark, which the scoreboard catches on the next presented word. A read state stuck in ST_HOLD, or a gate that opens early, shows up on the first packet. The symptoms are:
- a gap inside a packet under a gap-free writer;
- a start word presented while `rd_aempty` was still high;
- a lone non-final word presented during a long wait.

A flag computed from the wrong occupancy shows up at once as `rd_aempty` or `rd_empty` disagreeing with the quiet-state values after fill and after drain.

// File: rtl/pkt_afifo_pkg.sv
`timescale 1ns/1ps
package pkt_afifo_pkg;

    // Read-side controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // between packets, waiting for the start gate
        ST_STREAM = 2'd1,   // inside a packet, one pop per cycle
        ST_HOLD   = 2'd2    // inside a packet, starved, waiting for data
    } rd_state_e;

endpackage

// File: rtl/pkt_afifo_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded pointer bus.
module pkt_afifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pkt_afifo_wr.sv
`timescale 1ns/1ps
// Write-side pointer, Gray encoding and full detection.
module pkt_afifo_wr #(
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic [PTR_W-1:0]  wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              push,
    output logic              full
);

    localparam logic [PTR_W-1:0] LVL_FULL = PTR_W'(DEPTH);

    logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, fill;

    // Gray to binary for the synchronized read pointer
    always_comb begin
        rbin_s[PTR_W-1] = rgray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign fill    = wbin - rbin_s;
    assign full    = (fill == LVL_FULL);
    assign push    = wr_en & ~full;
    assign wbin_nx = wbin + {{(PTR_W-1){1'b0}}, push};
    assign waddr   = wbin[ADDR_W-1:0];

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

endmodule

// File: rtl/pkt_afifo_rd.sv
`timescale 1ns/1ps
// Read-side occupancy, flags, start gate and streaming state machine.
module pkt_afifo_rd
    import pkt_afifo_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int START_LEVEL = 2,
    parameter int AE_LEVEL    = 1,
    localparam int PTR_W      = ADDR_W + 1,
    localparam int WORD_W     = DATA_W + 2
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [PTR_W-1:0]  wgray_s,
    input  logic [WORD_W-1:0] head_word,
    output logic [PTR_W-1:0]  rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic              rd_valid,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_aempty
);

    localparam logic [PTR_W-1:0] LVL_START = PTR_W'(START_LEVEL);
    localparam logic [PTR_W-1:0] LVL_AE    = PTR_W'(AE_LEVEL);

    rd_state_e        state, state_nx;
    logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, level;
    logic             pop, head_eop, gate_open;

    // Gray to binary for the synchronized write pointer
    always_comb begin
        wbin_s[PTR_W-1] = wgray_s[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign level     = wbin_s - rbin;
    assign rd_empty  = (level == '0);
    assign rd_aempty = (level <= LVL_AE);
    assign head_eop  = head_word[DATA_W];
    assign gate_open = (level >= LVL_START) || (!rd_empty && head_eop);
    assign raddr     = rbin[ADDR_W-1:0];

    // Next state and pop decision
    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (gate_open) begin
                    pop      = 1'b1;
                    state_nx = head_eop ? ST_IDLE : ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (rd_empty) begin
                    state_nx = ST_HOLD;
                end else begin
                    pop      = 1'b1;
                    state_nx = head_eop ? ST_IDLE : ST_STREAM;
                end
            end
            ST_HOLD: begin
                if (!rd_empty) begin
                    pop      = 1'b1;
                    state_nx = head_eop ? ST_IDLE : ST_STREAM;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and read pointer
    assign rbin_nx = rbin + {{(PTR_W-1){1'b0}}, pop};

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            state <= ST_IDLE;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            state <= state_nx;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Registered outputs
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_valid <= 1'b0;
            rd_sop   <= 1'b0;
            rd_eop   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pop;
            if (pop) begin
                rd_sop  <= head_word[DATA_W+1];
                rd_eop  <= head_word[DATA_W];
                rd_data <= head_word[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pkt_afifo.sv
`timescale 1ns/1ps
// Dual-clock packet FIFO: storage plus the two pointer domains.
module pkt_afifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int START_LEVEL = 2,
    parameter int AE_LEVEL    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_aempty
);

    localparam int PTR_W  = ADDR_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = DATA_W + 2;

    logic [PTR_W-1:0]  wgray, wgray_s, rgray, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              push;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] head_word;

    pkt_afifo_wr #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .rgray_s  (rgray_s),
        .wgray    (wgray),
        .waddr    (waddr),
        .push     (push),
        .full     (wr_full)
    );

    pkt_afifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    pkt_afifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    // Storage: written in the write domain, read combinationally at the head
    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= {wr_sop, wr_eop, wr_data};
    end

    assign head_word = mem[raddr];

    pkt_afifo_rd #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .START_LEVEL (START_LEVEL),
        .AE_LEVEL    (AE_LEVEL)
    ) u_rd (
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .wgray_s   (wgray_s),
        .head_word (head_word),
        .rgray     (rgray),
        .raddr     (raddr),
        .rd_valid  (rd_valid),
        .rd_sop    (rd_sop),
        .rd_eop    (rd_eop),
        .rd_data   (rd_data),
        .rd_empty  (rd_empty),
        .rd_aempty (rd_aempty)
    );

endmodule

// File: rtl/pkt_afifo_chk.sv
`timescale 1ns/1ps
// Port-level properties of the read side, bound to every pkt_afifo.
module pkt_afifo_chk (
    input logic rd_clk,
    input logic rd_rst_n,
    input logic rd_valid,
    input logic rd_sop,
    input logic rd_eop,
    input logic rd_empty,
    input logic rd_aempty
);

    logic in_pkt;

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)     in_pkt <= 1'b0;
        else if (rd_valid) in_pkt <= !rd_eop;
    end

    AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_empty |-> rd_aempty);                                            // R5

    // With default levels (AE_LEVEL < START_LEVEL) a multi-word start needs aempty low one cycle earlier
    AST_START_GATE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && rd_sop && !rd_eop && !in_pkt) |-> $past(!rd_aempty));   // R3

    AST_NO_GAP_WITH_DATA: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_eop && !rd_empty) |=> rd_valid);                    // R6

    AST_PKT_OPENS_WITH_SOP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !in_pkt) |-> rd_sop);                                   // R2

    AST_NO_SOP_INSIDE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && in_pkt) |-> !rd_sop);                                   // R2

endmodule

bind pkt_afifo pkt_afifo_chk u_chk (
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_valid  (rd_valid),
    .rd_sop    (rd_sop),
    .rd_eop    (rd_eop),
    .rd_empty  (rd_empty),
    .rd_aempty (rd_aempty)
);

// File: tb/pkt_afifo_tb.sv
`timescale 1ns/1ps
module pkt_afifo_tb;

    localparam int DW = 8;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n;
    logic          wr_en, wr_sop, wr_eop;
    logic [DW-1:0] wr_data;
    logic          wr_full;
    logic          rd_valid, rd_sop, rd_eop, rd_empty, rd_aempty;
    logic [DW-1:0] rd_data;

    // 50 MHz write clock; read clock a touch slower, separate source
    always #10    wr_clk = ~wr_clk;
    always #10.05 rd_clk = ~rd_clk;

    pkt_afifo #(.DATA_W(DW)) u_dut (
        .wr_clk, .wr_rst_n, .wr_en, .wr_sop, .wr_eop, .wr_data, .wr_full,
        .rd_clk, .rd_rst_n, .rd_valid, .rd_sop, .rd_eop, .rd_data,
        .rd_empty, .rd_aempty
    );

    logic [DW+1:0] exp_q [$];
    int  n_checks = 0;
    int  n_fail   = 0;
    int  n_valid  = 0;
    int  n_gaps   = 0;
    int  n_ae_low = 0;
    int  seq      = 0;
    bit  contig_mode = 1'b1;
    bit  in_pkt      = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard: samples away from the rising read edge
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (!rd_aempty) n_ae_low++;
            if (rd_valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "word with nothing expected",
                          int'({rd_sop, rd_eop, rd_data}), -1);
                end else begin
                    logic [DW+1:0] e;
                    e = exp_q.pop_front();
                    check({rd_sop, rd_eop, rd_data} == e, "R2", "word/marks",
                          int'({rd_sop, rd_eop, rd_data}), int'(e));
                end
                in_pkt = !rd_eop;
            end else if (in_pkt) begin
                n_gaps++;
                if (contig_mode) check(1'b0, "R6", "gap inside packet", 0, 1);
            end
        end
    end

    // Driver
    task automatic write_word(input bit s, input bit e, input logic [DW-1:0] d);
        @(negedge wr_clk);
        while (wr_full) @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_sop  = s;
        wr_eop  = e;
        wr_data = d;
        exp_q.push_back({s, e, d});
    endtask

    task automatic idle_wr(input int n);
        @(negedge wr_clk);
        wr_en = 1'b0;
        repeat (n - 1) @(negedge wr_clk);
    endtask

    task automatic send_packet(input int len, input int gap_after, input int gap_len);
        for (int i = 0; i < len; i++) begin
            seq++;
            write_word(i == 0, i == len - 1, DW'(seq * 37 + 5));
            if (gap_len > 0 && i == gap_after - 1 && i != len - 1) idle_wr(gap_len);
        end
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge rd_clk);
            if (exp_q.size() == 0 && rd_empty) break;
        end
        repeat (3) @(negedge rd_clk);
    endtask

    // Watchdog
    initial begin
        #3_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int nv;
        int g0;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_data = '0;
        repeat (5) @(negedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge rd_clk);

        // R1: reset state
        check(rd_empty  == 1'b1, "R1", "rd_empty after reset",  rd_empty,  1);
        check(rd_aempty == 1'b1, "R1", "rd_aempty after reset", rd_aempty, 1);
        check(rd_valid  == 1'b0, "R1", "rd_valid after reset",  rd_valid,  0);
        check(wr_full   == 1'b0, "R1", "wr_full after reset",   wr_full,   0);

        // R3/R5: one non-final word held while filling from empty
        write_word(1'b1, 1'b0, 8'hA1);
        idle_wr(1);
        repeat (12) @(negedge rd_clk);
        check(n_valid == 0,      "R3", "words out with one held", n_valid, 0);
        check(rd_aempty == 1'b1, "R5", "aempty while filling",    rd_aempty, 1);
        check(rd_empty == 1'b0,  "R8", "empty with one held",     rd_empty, 0);
        write_word(1'b0, 1'b1, 8'hA2);
        idle_wr(1);
        wait_drain();
        check(n_valid == 2,      "R3", "words out after second", n_valid, 2);
        check(rd_empty == 1'b1,  "R8", "empty after drain",      rd_empty, 1);
        check(rd_aempty == 1'b1, "R5", "aempty after drain",     rd_aempty, 1);

        // R4: single-word packet
        nv = n_valid;
        write_word(1'b1, 1'b1, 8'h5B);
        idle_wr(1);
        repeat (10) @(negedge rd_clk);
        check(n_valid == nv + 1, "R4", "single-word packet out", n_valid - nv, 1);

        // R6/R5/R2: back-to-back packets under the gap-free contract
        n_ae_low = 0;
        g0 = n_gaps;
        send_packet(2, 0, 0);
        send_packet(3, 0, 0);
        send_packet(8, 0, 0);
        send_packet(40, 0, 0);
        send_packet(1, 0, 0);
        send_packet(5, 0, 0);
        idle_wr(1);
        wait_drain();
        check(n_gaps == g0,          "R6", "gaps under contract", n_gaps - g0, 0);
        check(n_ae_low > 0,          "R5", "aempty low during stream", n_ae_low, 1);
        check(exp_q.size() == 0,     "R2", "words left unread", exp_q.size(), 0);

        // R7: writer pauses inside a packet
        contig_mode = 1'b0;
        g0 = n_gaps;
        nv = n_valid;
        send_packet(10, 4, 8);
        idle_wr(1);
        wait_drain();
        check(n_gaps > g0,           "R7", "pause seen on output", n_gaps - g0, 1);
        check(n_valid == nv + 10,    "R7", "words after pause", n_valid - nv, 10);
        check(exp_q.size() == 0,     "R7", "words left unread", exp_q.size(), 0);

        // R8: quiet end state
        check(rd_empty == 1'b1,  "R8", "final rd_empty",  rd_empty,  1);
        check(rd_aempty == 1'b1, "R8", "final rd_aempty", rd_aempty, 1);
        check(wr_full == 1'b0,   "R1", "final wr_full",   wr_full,   0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule